// File: doc/BRIEF.md
# Latched-Read Timestamp Counter

A 40-bit free-running time base that software samples over a 32-bit register bus. The counter advances by one on every cycle where the fast-rate tick enable is high and counting is switched on. It never raises an interrupt; it is used only as a time stamp and as a clock source.

A 40-bit value cannot be fetched in one bus access, so a read of the low word does two things at once. It returns count bits 31:0, and on the same clock edge it copies bits 39:32 into a shadow byte. Software reads the low word first, then the high register, and joins the two halves. The result is coherent even if the counter carries into the upper byte between the two accesses. The high register also carries the run bit that starts and stops counting.

Top module: `tsc40`

## Requirements
- R1: After reset the count, the shadow byte and the run bit are zero, and `rdata_o` and `rvalid_o` are low.
- R2: While the run bit is 1, the count rises by exactly one on each cycle with `tick_i` high. With the run bit at 0, or with `tick_i` low, the count holds.
- R3: On a tick, the count wraps from all ones to zero.
- R4: A read (`req_i`=1, `we_i`=0) returns its data on `rdata_o` in the next cycle, with `rvalid_o` high for exactly that cycle. `rdata_o` is zero in every cycle where `rvalid_o` is low.
- R5: A read at byte address 0x60 returns count bits 31:0 as they stood in the request cycle. On the same edge it loads count bits 39:32 into the shadow byte. The shadow byte changes in no other way.
- R6: A read at byte address 0x64 returns the shadow byte in bits 7:0, the run bit in bit 8, and zero in bits 31:9.
- R7: A write at 0x64 sets the run bit to `wdata_i[8]`. All other data bits are ignored, and the shadow byte is unchanged.
- R8: A write at 0x60 has no effect. The count is unchanged by it.
- R9: A read at any other address returns zero. A write at any other address has no effect.
- R10: A tick and a low-word read in the same cycle return the pre-increment count. The shadow byte then matches that same pre-increment value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Fast-rate count enable, one cycle per tick |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
A tick and a low-word read can fall on the same edge. In that case the returned word must be the value from before the increment, and the shadow byte must agree with it. A run-bit write can also coincide with a tick; the tick is then judged against the run bit that was in force before the write. The bench issues reads and writes with `tick_i` held high, so both collisions happen many times. A reference model checks every returned word. The model applies the read and the snapshot before the increment, and the increment before the run-bit update. A second instance with a 4-bit low field and a 4-bit high field lets the carry into the shadow byte, and the wrap, occur within a short run.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned RUN_BIT = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } sel_e;
endpackage

// File: rtl/tsc_decode.sv
module tsc_decode #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h64
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output tsc_pkg::sel_e     sel_o,
  output logic              rd_o,
  output logic              rd_lo_o,
  output logic              wr_hi_o
);
  import tsc_pkg::*;

  always_comb begin
    if (addr_i == LO_ADDR)      sel_o = SEL_LO;
    else if (addr_i == HI_ADDR) sel_o = SEL_HI;
    else                        sel_o = SEL_NONE;
  end

  assign rd_o    = req_i && !we_i;
  assign rd_lo_o = rd_o && (sel_o == SEL_LO);
  // low-word and unmapped writes decode to nothing
  assign wr_hi_o = req_i && we_i && (sel_o == SEL_HI);
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic step;
  assign step = run_i && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (step) cnt_o <= cnt_o + 1'b1;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && tick_i) |=> $stable(cnt_o));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_o != CNT_MAX) |=> (cnt_o - $past(cnt_o)) == CNT_W'(1));
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_o == CNT_MAX) |=> cnt_o == '0);
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl #(
  parameter int unsigned HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_lo_i,
  input  logic            wr_hi_i,
  input  logic            run_wdata_i,
  input  logic [HI_W-1:0] cnt_hi_i,
  output logic [HI_W-1:0] snap_o,
  output logic            run_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_o <= '0;
      run_o  <= 1'b0;
    end else begin
      if (rd_lo_i) snap_o <= cnt_hi_i;
      if (wr_hi_i) run_o  <= run_wdata_i;
    end
  end

  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> snap_o == $past(cnt_hi_i));
  a_r5_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo_i |=> $stable(snap_o));
  a_r7_run_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> run_o == $past(run_wdata_i));
  a_r8_run_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi_i |=> $stable(run_o));
endmodule

// File: rtl/tsc_rdport.sv
module tsc_rdport #(
  parameter int unsigned LO_W = 32,
  parameter int unsigned HI_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_i,
  input  tsc_pkg::sel_e             sel_i,
  input  logic [LO_W-1:0]           cnt_lo_i,
  input  logic [HI_W-1:0]           snap_i,
  input  logic                      run_i,
  output logic [tsc_pkg::BUS_W-1:0] rdata_o,
  output logic                      rvalid_o
);
  import tsc_pkg::*;

  logic [BUS_W-1:0] lo_word, hi_word, rd_mux;

  always_comb begin
    lo_word = '0;
    lo_word[LO_W-1:0] = cnt_lo_i;
    hi_word = '0;
    hi_word[HI_W-1:0] = snap_i;
    hi_word[RUN_BIT]  = run_i;
    unique case (sel_i)
      SEL_LO:  rd_mux = lo_word;
      SEL_HI:  rd_mux = hi_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? rd_mux : '0;
    end
  end

  a_r4_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (!rvalid_o && rdata_o == '0));
  a_r9_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_NONE) |=> rdata_o == '0);
  a_r6_hi_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_HI) |=> rdata_o[BUS_W-1:RUN_BIT+1] == '0);
endmodule

// File: rtl/tsc40.sv
module tsc40 #(
  parameter int unsigned LO_W   = 32,
  parameter int unsigned HI_W   = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  import tsc_pkg::*;

  localparam int unsigned CNT_W = LO_W + HI_W;

  sel_e             sel;
  logic             rd, rd_lo, wr_hi, run;
  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  snap;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[31:RUN_BIT+1], wdata_i[RUN_BIT-1:0]};

  tsc_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .sel_o   (sel),
    .rd_o    (rd),
    .rd_lo_o (rd_lo),
    .wr_hi_o (wr_hi)
  );

  tsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run),
    .cnt_o  (cnt)
  );

  tsc_ctrl #(.HI_W(HI_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_lo_i     (rd_lo),
    .wr_hi_i     (wr_hi),
    .run_wdata_i (wdata_i[RUN_BIT]),
    .cnt_hi_i    (cnt[CNT_W-1:LO_W]),
    .snap_o      (snap),
    .run_o       (run)
  );

  tsc_rdport #(.LO_W(LO_W), .HI_W(HI_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd),
    .sel_i    (sel),
    .cnt_lo_i (cnt[LO_W-1:0]),
    .snap_i   (snap),
    .run_i    (run),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // R10: returned low word and captured byte come from the same pre-edge count
  a_r10_coherent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> {snap, rdata_o[LO_W-1:0]} == $past(cnt));
  a_r8_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && sel == SEL_LO && !(run && tick_i)) |=> $stable(cnt));
endmodule

// File: tb/tsc40_test.sv
module tsc40_test;
  localparam logic [7:0] A_LO = 8'h60;
  localparam logic [7:0] A_HI = 8'h64;
  localparam logic [7:0] A_NX = 8'h68;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic        rvalid, rvalid_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [39:0] mcnt = '0;
  logic        mrun = 1'b0;
  logic [7:0]  msnap = '0;
  logic [3:0]  msnap_s = '0;

  logic [31:0] exp_q[$];
  logic [31:0] exps_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  tsc40 uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  tsc40 #(.LO_W(4), .HI_W(4)) uut_small (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_s), .rvalid_o(rvalid_s)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, predicts then advances one cycle
  task automatic cyc(input logic tk, input logic rq, input logic w,
                     input logic [7:0] a, input logic [31:0] d, input string tag);
    tick = tk; req = rq; we = w; addr = a; wdata = d;
    if (rq && !w) begin
      if (a == A_LO) begin
        exp_q.push_back(mcnt[31:0]);
        exps_q.push_back({28'b0, mcnt[3:0]});
        msnap   = mcnt[39:32];
        msnap_s = mcnt[7:4];
      end else if (a == A_HI) begin
        exp_q.push_back({23'b0, mrun, msnap});
        exps_q.push_back({23'b0, mrun, 4'b0, msnap_s});
      end else begin
        exp_q.push_back('0);
        exps_q.push_back('0);
      end
      tag_q.push_back(tag);
    end
    if (tk && mrun) mcnt = mcnt + 1'b1;
    if (rq && w && a == A_HI) mrun = d[8];
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; req = 1'b0; we = 1'b0;
  endtask

  // monitor: pops expected read data when the design presents it
  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (rvalid !== rvalid_s) begin
        errors++;
        $display("FAIL R4 valid mismatch actual=%b expected=%b", rvalid_s, rvalid);
      end
      if (rvalid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected rvalid actual=1 expected=0");
        end else begin
          automatic string t = tag_q.pop_front();
          check(t, rdata, exp_q.pop_front());
          check({t, " small"}, rdata_s, exps_q.pop_front());
        end
      end else begin
        check("R4 idle data", rdata, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset rvalid", {31'b0, rvalid}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    cyc(0, 1, 0, A_LO, 0, "R1 low after reset");
    cyc(0, 1, 0, A_HI, 0, "R1 high after reset");

    // ticks with run bit clear
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, "");
    cyc(0, 1, 0, A_LO, 0, "R2 hold while stopped");

    // start counting, other data bits set
    cyc(0, 1, 1, A_HI, 32'h0000_01FF, "");
    cyc(0, 1, 0, A_HI, 0, "R7 run bit set");
    cyc(0, 1, 0, A_LO, 0, "R2 no tick no count");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0, "");
    cyc(0, 1, 0, A_LO, 0, "R2 ten ticks");
    for (int i = 0; i < 12; i++) cyc(i % 3 == 0, 0, 0, 0, 0, "");
    cyc(0, 1, 0, A_LO, 0, "R2 sparse ticks");
    cyc(0, 1, 0, A_HI, 0, "R6 high layout");

    // write to low word is ignored
    cyc(0, 1, 1, A_LO, 32'hDEAD_BEEF, "");
    cyc(0, 1, 0, A_LO, 0, "R8 low write ignored");
    cyc(1, 1, 1, A_LO, 32'hFFFF_FFFF, "");
    cyc(0, 1, 0, A_LO, 0, "R8 low write with tick");

    // unmapped address
    cyc(0, 1, 0, A_NX, 0, "R9 unmapped read");
    cyc(0, 1, 1, A_NX, 32'hFFFF_FFFF, "");
    cyc(0, 1, 0, A_HI, 0, "R9 unmapped write no effect");

    // tick coinciding with low read
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, A_LO, 0, "R10 tick with low read");
    cyc(1, 1, 0, A_HI, 0, "R10 snapshot matches");

    // run long enough for the small instance to carry and wrap
    for (int i = 0; i < 300; i++) begin
      if (i % 17 == 0) cyc(1, 1, 0, A_LO, 0, "R3 wrap low read");
      else if (i % 17 == 1) cyc(1, 1, 0, A_HI, 0, "R5 snapshot read");
      else cyc(1, 0, 0, 0, 0, "");
    end

    // snapshot persists across later ticks
    cyc(1, 1, 0, A_LO, 0, "R5 capture");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0, "");
    cyc(1, 1, 0, A_HI, 0, "R5 snapshot stable");

    // stop with other bits set, run-bit write coinciding with tick
    cyc(1, 1, 1, A_HI, 32'hFFFF_FEFF, "");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, "");
    cyc(0, 1, 0, A_LO, 0, "R7 stopped by write");
    cyc(0, 1, 0, A_HI, 0, "R7 run bit cleared");
    cyc(0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, "");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule